// File: doc/BRIEF.md
# Fine Attribute Remapping Unit

This block sits on the picture-processor address bus, between the console and the cartridge memories. It gives each 8x8-pixel tile its own colour-attribute zone. It watches picture-processor reads and sorts each address into one of three kinds:

- a pattern fetch, when address bit 13 is low;
- a nametable fetch, when bit 13 is high and the address is not an attribute fetch;
- an attribute fetch, when bit 13 is high and bits 9..6 are all ones.

On a nametable read, the unit keeps the lowest coarse-X bit (address bit 0) and the lowest coarse-Y bit (address bit 5). On the attribute read that follows, it keeps the console nametable RAM off the bus and turns on the CHR-RAM instead. It then drives the two upper CHR-RAM address lines from the captured pair. The attribute byte is therefore fetched from one of four 8 KiB CHR-RAM banks, chosen by where the tile sits.

Outside attribute fetches, the CPU chooses the CHR bank. A one-cycle CPU write strobe loads a small bank register that drives the same upper address lines. Everything is sampled on a single clock. The read strobe and the address are assumed stable for the clock cycle of an access.

Top module: `fine_attr_remap`

## Requirements
- R1: After reset (rstN low, asynchronous), both the CPU bank register and the captured coarse pair are zero, so a pattern read drives chrAddrHi = 0.
- R2: With ppuRdN high, ntRamOeN and chrOeN are both high (inactive). During a read, ntRamOeN is low only for a nametable fetch, and chrOeN is low only for a pattern or attribute fetch.
- R3: A clock edge during a nametable read (ppuRdN low, bit 13 high, bits 9..6 not all ones) loads the captured pair: address bit 0 goes to chrAddrHi[0] and address bit 5 goes to chrAddrHi[1]. Without a read strobe, nothing is captured.
- R4: While the address is an attribute fetch (bit 13 high, bits 9..6 all ones), chrAddrHi shows the captured pair as chrAddrHi = {bit5, bit0}.
- R5: At every address that is not an attribute fetch, chrAddrHi shows the CPU bank register.
- R6: A clock edge with cpuBankWr high loads cpuData into the CPU bank register. The new value is visible from the next cycle, including when the write happens during an attribute fetch.
- R7: Attribute fetches, pattern fetches, and idle cycles leave the captured pair unchanged. This includes pattern addresses whose bits 9..6 are all ones.
- R8: A pattern fetch (bit 13 low) never enables the nametable RAM. It enables the CHR-RAM during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ppuAddr | input | 14 | Picture-processor address bus |
| ppuRdN | input | 1 | Picture-processor read strobe, active low |
| cpuBankWr | input | 1 | One-cycle CPU bank-register write strobe from the CPU-side decoder |
| cpuData | input | 2 | CPU data bits loaded as the bank number |
| ntRamOeN | output | 1 | Console nametable RAM output enable, active low |
| chrOeN | output | 1 | CHR-RAM output enable, active low |
| chrAddrHi | output | 2 | CHR-RAM address bits 14..13 (bank select) |

## Verification
The hardest situation to reach is a nametable address presented to the unit without the read strobe, or an attribute-shaped address that has bit 13 low. In both cases the captured pair must stay as it was. A wrong value shows only on the next attribute fetch, never on the access itself. The stimulus therefore sets up a known captured pair with a real nametable read. It then applies the decoy access, and follows it at once with an attribute fetch, whose upper address lines reveal whether the pair moved. A bank write placed inside an attribute fetch is checked in the same way: the following pattern fetch must show the new bank.

// File: rtl/fine_attr_pkg.sv
package fine_attr_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    FETCH_PATTERN = 2'd0,
    FETCH_NAME    = 2'd1,
    FETCH_ATTR    = 2'd2
  } fetch_kind_e;

  typedef struct packed {
    logic capture;
    logic attrSel;
    logic bankLoad;
    logic ntOe;
    logic chrOe;
  } remap_strobe_t;

endpackage

// File: rtl/fine_attr_ctrl.sv
module fine_attr_ctrl
  import fine_attr_pkg::*;
#(
  parameter int ATTR_W = 4
) (
  input  logic              tableBit,
  input  logic [ATTR_W-1:0] attrField,
  input  logic              ppuRdN,
  input  logic              cpuBankWr,
  output remap_strobe_t     strobe
);

  fetch_kind_e kind;
  logic        rdActive;

  always_comb begin
    if (!tableBit)
      kind = FETCH_PATTERN;
    else if (&attrField)
      kind = FETCH_ATTR;
    else
      kind = FETCH_NAME;
  end

  assign rdActive = ~ppuRdN;

  always_comb begin
    strobe          = '0;
    strobe.attrSel  = (kind == FETCH_ATTR);
    strobe.capture  = rdActive && (kind == FETCH_NAME);
    strobe.ntOe     = rdActive && (kind == FETCH_NAME);
    strobe.chrOe    = rdActive && (kind != FETCH_NAME);
    strobe.bankLoad = cpuBankWr;
  end

endmodule

// File: rtl/fine_attr_dpath.sv
module fine_attr_dpath
  import fine_attr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  remap_strobe_t    strobe,
  input  logic [SEL_W-1:0] coarsePair,
  input  logic [SEL_W-1:0] cpuData,
  output logic             ntRamOeN,
  output logic             chrOeN,
  output logic [SEL_W-1:0] chrAddrHi
);

  logic [SEL_W-1:0] pairQ;
  logic [SEL_W-1:0] bankQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pairQ <= '0;
    else if (strobe.capture)
      pairQ <= coarsePair;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bankQ <= '0;
    else if (strobe.bankLoad)
      bankQ <= cpuData;
  end

  assign chrAddrHi = strobe.attrSel ? pairQ : bankQ;
  assign ntRamOeN  = ~strobe.ntOe;
  assign chrOeN    = ~strobe.chrOe;

endmodule

// File: rtl/fine_attr_remap.sv
module fine_attr_remap
  import fine_attr_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int TABLE_BIT = 13,
  parameter int ATTR_LSB  = 6,
  parameter int ATTR_MSB  = 9,
  parameter int XBIT      = 0,
  parameter int YBIT      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ppuAddr,
  input  logic              ppuRdN,
  input  logic              cpuBankWr,
  input  logic [SEL_W-1:0]  cpuData,
  output logic              ntRamOeN,
  output logic              chrOeN,
  output logic [SEL_W-1:0]  chrAddrHi
);

  localparam int ATTR_W = ATTR_MSB - ATTR_LSB + 1;

  remap_strobe_t    strobe;
  logic [SEL_W-1:0] coarsePair;
  logic             unusedAddr;

  assign coarsePair = {ppuAddr[YBIT], ppuAddr[XBIT]};
  assign unusedAddr = ^ppuAddr;

  fine_attr_ctrl #(.ATTR_W(ATTR_W)) ctrl_i (
    .tableBit (ppuAddr[TABLE_BIT]),
    .attrField(ppuAddr[ATTR_MSB:ATTR_LSB]),
    .ppuRdN   (ppuRdN),
    .cpuBankWr(cpuBankWr),
    .strobe   (strobe)
  );

  fine_attr_dpath dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .coarsePair(coarsePair),
    .cpuData   (cpuData),
    .ntRamOeN  (ntRamOeN),
    .chrOeN    (chrOeN),
    .chrAddrHi (chrAddrHi)
  );

endmodule

// File: rtl/fine_attr_remap_chk.sv
module fine_attr_remap_chk (
  input logic        clk,
  input logic        rstN,
  input logic [13:0] ppuAddr,
  input logic        ppuRdN,
  input logic        cpuBankWr,
  input logic [1:0]  cpuData,
  input logic        ntRamOeN,
  input logic        chrOeN,
  input logic [1:0]  chrAddrHi
);

  logic isAttr;
  logic isName;

  assign isAttr = ppuAddr[13] && (&ppuAddr[9:6]);
  assign isName = ppuAddr[13] && !(&ppuAddr[9:6]);

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    ppuRdN |-> (ntRamOeN && chrOeN));

  // R2
  attr_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ppuRdN && isAttr) |-> (ntRamOeN && !chrOeN));

  // R3
  capture_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ppuRdN && isName) |=> (isAttr |-> chrAddrHi == {$past(ppuAddr[5]), $past(ppuAddr[0])}));

  // R6
  bank_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuBankWr |=> (!isAttr |-> chrAddrHi == $past(cpuData)));

  // R8
  pattern_no_nt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ppuAddr[13] |-> ntRamOeN);

  // R7
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isAttr && !ppuRdN) |=> (isAttr |-> $stable(chrAddrHi)));

endmodule

bind fine_attr_remap fine_attr_remap_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ppuAddr  (ppuAddr),
  .ppuRdN   (ppuRdN),
  .cpuBankWr(cpuBankWr),
  .cpuData  (cpuData),
  .ntRamOeN (ntRamOeN),
  .chrOeN   (chrOeN),
  .chrAddrHi(chrAddrHi)
);

// File: tb/fine_attr_remap_tb_top.sv
module fine_attr_remap_tb_top;

  typedef struct {
    logic       nt;
    logic       chr;
    logic [1:0] hi;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] ppuAddr = '0;
  logic        ppuRdN = 1'b1;
  logic        cpuBankWr = 1'b0;
  logic [1:0]  cpuData = '0;
  logic        ntRamOeN;
  logic        chrOeN;
  logic [1:0]  chrAddrHi;

  exp_t expQ[$];
  int   checks = 0;
  int   fails = 0;
  logic [1:0] modelBank = '0;
  logic [1:0] modelPair = '0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  fine_attr_remap dut_i (
    .clk(clk), .rstN(rstN), .ppuAddr(ppuAddr), .ppuRdN(ppuRdN),
    .cpuBankWr(cpuBankWr), .cpuData(cpuData),
    .ntRamOeN(ntRamOeN), .chrOeN(chrOeN), .chrAddrHi(chrAddrHi)
  );

  task automatic access(input logic [13:0] a, input logic rd, input logic wr,
                        input logic [1:0] d, input string tag);
    exp_t e;
    logic tbl;
    logic attr;
    @(posedge clk);
    #1;
    ppuAddr = a; ppuRdN = ~rd; cpuBankWr = wr; cpuData = d;
    tbl  = a[13];
    attr = tbl && (a[9:6] == 4'b1111);
    e.nt  = !(rd && tbl && !attr);
    e.chr = !(rd && !(tbl && !attr));
    e.hi  = attr ? modelPair : modelBank;
    e.tag = tag;
    expQ.push_back(e);
    if (wr) modelBank = d;
    if (rd && tbl && !attr) modelPair = {a[5], a[0]};
  endtask

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (ntRamOeN !== e.nt || chrOeN !== e.chr || chrAddrHi !== e.hi) begin
        fails++;
        $display("FAIL %s: got nt=%b chr=%b hi=%0d, expected nt=%b chr=%b hi=%0d",
                 e.tag, ntRamOeN, chrOeN, chrAddrHi, e.nt, e.chr, e.hi);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state seen through a pattern read and an attribute read
    access(14'h0123, 1, 0, 2'd0, "R1 reset bank");
    access(14'h23C0, 1, 0, 2'd0, "R1 reset pair");
    // R2: idle bus
    access(14'h2000, 0, 0, 2'd0, "R2 idle");
    access(14'h0040, 0, 0, 2'd0, "R2 idle pattern");
    // R6: bank write, new value from the next cycle on
    access(14'h0100, 1, 1, 2'd2, "R6 write cycle");
    access(14'h0100, 1, 0, 2'd0, "R6 bank visible");
    // R3/R4: nametable capture, then attribute redirect
    access(14'h2021, 1, 0, 2'd0, "R5 nametable uses bank");
    access(14'h23C9, 1, 0, 2'd0, "R4 attr pair 3");
    access(14'h0010, 1, 0, 2'd0, "R5 pattern after attr");
    access(14'h27D2, 1, 0, 2'd0, "R7 attr hold");
    access(14'h2000, 1, 0, 2'd0, "R3 capture 0");
    access(14'h2BC0, 1, 0, 2'd0, "R4 attr pair 0");
    access(14'h2001, 1, 0, 2'd0, "R3 capture x");
    access(14'h23C1, 1, 0, 2'd0, "R4 attr pair 1");
    access(14'h2020, 1, 0, 2'd0, "R3 capture y");
    access(14'h3FC0, 1, 0, 2'd0, "R4 attr pair 2");
    // R3: near-attribute nametable address (bits 9..6 = 1110)
    access(14'h2381, 1, 0, 2'd0, "R3 near attr name");
    access(14'h23C0, 1, 0, 2'd0, "R4 attr after near");
    // R3: nametable address without read strobe must not capture
    access(14'h2020, 0, 0, 2'd0, "R3 no strobe");
    access(14'h23C0, 1, 0, 2'd0, "R3 pair kept");
    // R8/R7: attribute-shaped pattern address
    access(14'h03C0, 1, 0, 2'd0, "R8 pattern no nt");
    access(14'h23C0, 1, 0, 2'd0, "R7 pair kept after pattern");
    // R6: bank write during attribute fetch
    access(14'h23C0, 1, 1, 2'd3, "R6 write in attr");
    access(14'h0200, 1, 0, 2'd0, "R6 bank after attr write");
    access(14'h2C21, 1, 0, 2'd0, "R5 nametable bank 3");
    access(14'h2FE0, 1, 0, 2'd0, "R4 attr after new name");
    access(14'h0000, 0, 0, 2'd0, "R2 final idle");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule